// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit count that runs down by one on each cycle with `tick` high. In a system, `tick` is a strobe at about 1.19318 MHz derived from the core clock. Software reaches the channel through an 8-bit data port and through fields decoded from a control word that several channels share. The 16-bit count is written as two bytes, low byte first. The count can also be read back as two bytes. A latch command freezes a copy of the count so that the two reads return a value that belongs together.

The channel has three counting behaviours. The one-shot mode raises the output once when the count expires. The rate generator reloads from the programmed period and drops the output for one count step. The square wave mode reloads from the period and keeps the output high for the first half of each period. A control word that asks for a setting the channel does not support leaves the configuration as it was and sets a sticky error flag.

Top module: `ivc_channel`

## Requirements
- R1: A control write (`ctrl_we`) acts only when `ctrl_sel` equals the parameter `CHAN_ID`. Access code 2'b00 is a latch command, and the mode and BCD fields are then ignored. Access code 2'b11 with BCD 0 and mode 3'b000 (one-shot), 3'b010 (rate generator) or 3'b011 (square wave) sets the mode.
- R2: A selected control write with access code 2'b01 or 2'b10, with any other mode code, or with BCD 1 sets `cfg_err` and does not change the mode. `cfg_err` then stays high until reset, even after valid writes.
- R3: Data writes alternate between low byte and high byte, and the first write after reset is a low byte. A low-byte write replaces bits 7:0 of the count, stops counting and drives `out_bit` low.
- R4: A high-byte write replaces bits 15:8 of the count and stores the full 16-bit value as the period. Counting starts only when that value is nonzero. A zero value leaves the channel stopped with `out_bit` low.
- R5: `rdata` shows the byte that the read pointer selects. The low byte comes first after reset, and each `data_re` pulse moves the pointer to the other byte. With no latch pending, the bytes come from the live count.
- R6: A latch command with no latch pending copies the live count and moves the read pointer to the low byte. Reads then return the frozen copy. The latch is released by the read of its high byte. A latch command while one is pending has no effect.
- R7: While the channel is running, each cycle with `tick` high lowers the count by one. While the channel is stopped, the count holds.
- R8: In one-shot mode, the tick that takes the count from 1 to 0 drives `out_bit` high and stops the channel. `out_bit` stays high until the next low-byte write.
- R9: In rate generator mode, a tick at count 1 reloads the period. `out_bit` is low exactly while the count is 1.
- R10: In square wave mode, a tick at count 1 reloads the period. `out_bit` is high while the count is greater than the period divided by two (rounded down), and low otherwise.
- R11: A data write in the same cycle as a tick takes priority, and the tick has no effect in that cycle.
- R12: After reset the count is 0, the channel is stopped, `out_bit` and `cfg_err` are low, the mode is one-shot, both byte pointers select the low byte, and no latch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable strobe |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_sel | input | 2 | Channel select field of the control word |
| ctrl_acc | input | 2 | Access field: 00 latch, 11 low then high byte |
| ctrl_mode | input | 3 | Mode field of the control word |
| ctrl_bcd | input | 1 | BCD counting request (unsupported) |
| data_we | input | 1 | Data port write strobe |
| data_re | input | 1 | Data port read strobe; advances the read pointer |
| wdata | input | DATA_W | Byte written to the data port |
| rdata | output | DATA_W | Byte currently presented for reading |
| out_bit | output | 1 | Channel output, readable as a status flag |
| cfg_err | output | 1 | Sticky flag for an unsupported control setting |

## Verification
The assertions are checked on every cycle. They cover these relations:
- the stickiness of the error flag;
- a low-byte write stopping the channel and lowering the output;
- a zero load not starting the count;
- the count holding while stopped, and stepping by exactly one per tick while running;
- the reload from the period at count 1;
- the frozen latch copy;
- the one-shot output holding high;
- a write winning over a simultaneous tick.

Only the bench scenarios show the complete output waveforms of the rate generator and square wave modes over several periods. They also show that a second latch command is ignored, and that bad settings leave the previous mode in force.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
// Shared types of the interval counter channel.
// Mode codes match the control word mode field; access codes match the access field.
package ivc_pkg;
    typedef enum logic [2:0] {
        MODE_TC   = 3'b000,
        MODE_RATE = 3'b010,
        MODE_SQW  = 3'b011
    } ivc_mode_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ivc_ptr_e;

    localparam logic [1:0] ACC_LATCH = 2'b00;
    localparam logic [1:0] ACC_WORD  = 2'b11;
endpackage

// File: rtl/ivc_ctrl_decode.sv
`timescale 1ns/1ps
// Control word filter for one channel.
// It turns a selected control write into a one-cycle latch command, or into a mode update.
// Unsupported settings leave the mode alone and raise a sticky error.
// Assumes the control fields are valid in the cycle where ctrl_we is high.
module ivc_ctrl_decode
    import ivc_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [1:0] ctrl_sel,
    input  logic [1:0] ctrl_acc,
    input  logic [2:0] ctrl_mode,
    input  logic       ctrl_bcd,
    output logic       latch_cmd,
    output ivc_mode_e  mode,
    output logic       cfg_err
);
    logic hit;
    logic cfg_req;
    logic mode_ok;
    logic cfg_ok;

    // Decode which kind of control write addresses this channel.
    always_comb begin
        hit       = ctrl_we && (ctrl_sel == CHAN_ID);
        latch_cmd = hit && (ctrl_acc == ACC_LATCH);
        cfg_req   = hit && (ctrl_acc != ACC_LATCH);
        mode_ok   = (ctrl_mode == MODE_TC) || (ctrl_mode == MODE_RATE) ||
                    (ctrl_mode == MODE_SQW);
        cfg_ok    = (ctrl_acc == ACC_WORD) && !ctrl_bcd && mode_ok;
    end

    // Hold the mode, and record any unsupported request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_TC;
            cfg_err <= 1'b0;
        end else if (cfg_req) begin
            if (cfg_ok) begin
                mode <= ivc_mode_e'(ctrl_mode);
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivc_byte_port.sv
`timescale 1ns/1ps
// Byte sequencing for the data port.
// The write pointer alternates low and high byte and emits one strobe per half.
// The read pointer alternates over either the live count or a latched copy.
// Assumes at most one data write per cycle; reads and writes have independent pointers.
module ivc_byte_port
    import ivc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              data_re,
    input  logic              latch_cmd,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic              lo_wr,
    output logic              hi_wr
);
    ivc_ptr_e           wr_ptr_q;
    ivc_ptr_e           rd_ptr_q;
    logic               latch_on_q;
    logic [CNT_W-1:0]   latched_q;
    logic [CNT_W-1:0]   rd_src;

    // Pick the write half and the byte presented for reading.
    always_comb begin
        lo_wr  = data_we && (wr_ptr_q == PTR_LO);
        hi_wr  = data_we && (wr_ptr_q == PTR_HI);
        rd_src = latch_on_q ? latched_q : count;
        rdata  = (rd_ptr_q == PTR_HI) ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
    end

    // Toggle the write pointer on every data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= PTR_LO;
        end else if (data_we) begin
            wr_ptr_q <= (wr_ptr_q == PTR_LO) ? PTR_HI : PTR_LO;
        end
    end

    // Advance the read pointer, release the latch after its high byte, and take a new latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q   <= PTR_LO;
            latch_on_q <= 1'b0;
            latched_q  <= '0;
        end else begin
            if (data_re) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LO) ? PTR_HI : PTR_LO;
                if (latch_on_q && (rd_ptr_q == PTR_HI)) begin
                    latch_on_q <= 1'b0;
                end
            end
            if (latch_cmd && !latch_on_q) begin
                latch_on_q <= 1'b1;
                latched_q  <= count;
                rd_ptr_q   <= PTR_LO;
            end
        end
    end
endmodule

// File: rtl/ivc_down_counter.sv
`timescale 1ns/1ps
// Down counter with reload period and output shaping for the three supported modes.
// Assumes the write strobes come from the byte port, so at most one is high per cycle.
// A write always wins over a tick in the same cycle.
module ivc_down_counter
    import ivc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  ivc_mode_e         mode,
    output logic [CNT_W-1:0]  count,
    output logic              out_bit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] period_q;
    logic             running_q;
    logic             out_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] wrap_val;
    logic             at_one;
    logic             arm_out;
    logic             run_out;

    // Next-count candidates and the output level each mode asks for.
    always_comb begin
        load_val = {wdata, count_q[DATA_W-1:0]};
        dec_val  = count_q - ONE;
        at_one   = (count_q == ONE);
        wrap_val = at_one ? period_q : dec_val;
        case (mode)
            MODE_RATE: begin
                arm_out = (load_val != '0) && (load_val != ONE);
                run_out = (wrap_val != ONE);
            end
            MODE_SQW: begin
                arm_out = (load_val != '0);
                run_out = (wrap_val > (period_q >> 1));
            end
            default: begin
                arm_out = 1'b0;
                run_out = out_q;
            end
        endcase
    end

    // Load, stop, count and shape the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            period_q  <= '0;
            running_q <= 1'b0;
            out_q     <= 1'b0;
        end else if (lo_wr) begin
            count_q[DATA_W-1:0] <= wdata;
            running_q           <= 1'b0;
            out_q               <= 1'b0;
        end else if (hi_wr) begin
            count_q   <= load_val;
            period_q  <= load_val;
            running_q <= (load_val != '0);
            out_q     <= arm_out;
        end else if (tick && running_q) begin
            if (mode == MODE_TC) begin
                count_q <= dec_val;
                if (at_one) begin
                    running_q <= 1'b0;
                    out_q     <= 1'b1;
                end
            end else begin
                count_q <= wrap_val;
                out_q   <= run_out;
            end
        end
    end

    assign count   = count_q;
    assign out_bit = out_q;
endmodule

// File: rtl/ivc_channel.sv
`timescale 1ns/1ps
// One programmable interval counter channel.
// It joins the control word filter, the byte port and the down counter.
// Assumes tick is a single-cycle strobe at the counting rate and CHAN_ID is 0, 1 or 2.
module ivc_channel
    import ivc_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_sel,
    input  logic [1:0]        ctrl_acc,
    input  logic [2:0]        ctrl_mode,
    input  logic              ctrl_bcd,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              out_bit,
    output logic              cfg_err
);
    localparam int CNT_W = 2 * DATA_W;

    logic             latch_cmd;
    ivc_mode_e        mode;
    logic             lo_wr;
    logic             hi_wr;
    logic [CNT_W-1:0] count;

    ivc_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_sel  (ctrl_sel),
        .ctrl_acc  (ctrl_acc),
        .ctrl_mode (ctrl_mode),
        .ctrl_bcd  (ctrl_bcd),
        .latch_cmd (latch_cmd),
        .mode      (mode),
        .cfg_err   (cfg_err)
    );

    ivc_byte_port #(.DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_we   (data_we),
        .data_re   (data_re),
        .latch_cmd (latch_cmd),
        .count     (count),
        .rdata     (rdata),
        .lo_wr     (lo_wr),
        .hi_wr     (hi_wr)
    );

    ivc_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .wdata   (wdata),
        .mode    (mode),
        .count   (count),
        .out_bit (out_bit)
    );
endmodule

// File: rtl/ivc_channel_chk.sv
`timescale 1ns/1ps
// Property checker for ivc_channel, attached through bind below.
// It watches the ports and the state that the submodules hand to each other.
module ivc_channel_chk #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              data_we,
    input logic [DATA_W-1:0] wdata,
    input logic              out_bit,
    input logic              cfg_err,
    input logic              lo_wr,
    input logic              hi_wr,
    input logic [2:0]        mode,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic              running,
    input logic              latch_on,
    input logic [CNT_W-1:0]  latched
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R2
    AST_LO_WR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (!out_bit && !running)); // R3
    AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && (wdata == '0) && (count[DATA_W-1:0] == '0)) |=> !running); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !data_we) |=> $stable(count)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !data_we && (count > ONE)) |=> (count == $past(count) - ONE)); // R7
    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        latch_on |=> (!latch_on || $stable(latched))); // R6
    AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'b000) && out_bit && !running && !data_we) |=> out_bit); // R8
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !data_we && (mode != 3'b000) && (count == ONE))
        |=> (count == $past(period))); // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && tick) |=> (count[DATA_W-1:0] == $past(wdata))); // R11
endmodule

bind ivc_channel ivc_channel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .data_we  (data_we),
    .wdata    (wdata),
    .out_bit  (out_bit),
    .cfg_err  (cfg_err),
    .lo_wr    (lo_wr),
    .hi_wr    (hi_wr),
    .mode     (mode),
    .count    (count),
    .period   (u_cnt.period_q),
    .running  (u_cnt.running_q),
    .latch_on (u_port.latch_on_q),
    .latched  (u_port.latched_q)
);

// File: tb/ivc_channel_tb.sv
`timescale 1ns/1ps
module ivc_channel_tb;
    localparam int DW = 8;
    localparam logic [1:0] CH = 2'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [1:0]    ctrl_sel = '0;
    logic [1:0]    ctrl_acc = '0;
    logic [2:0]    ctrl_mode = '0;
    logic          ctrl_bcd = 1'b0;
    logic          data_we = 1'b0;
    logic          data_re = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          out_bit;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;

    ivc_channel #(.DATA_W(DW), .CHAN_ID(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we), .ctrl_sel(ctrl_sel),
        .ctrl_acc(ctrl_acc), .ctrl_mode(ctrl_mode), .ctrl_bcd(ctrl_bcd),
        .data_we(data_we), .data_re(data_re), .wdata(wdata), .rdata(rdata),
        .out_bit(out_bit), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; ctrl_we = 1'b0; data_we = 1'b0; data_re = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ctrl(logic [1:0] sel, logic [1:0] acc, logic [2:0] md, logic bcd);
        ctrl_sel = sel; ctrl_acc = acc; ctrl_mode = md; ctrl_bcd = bcd; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic set_mode(logic [2:0] md);
        ctrl(CH, 2'b11, md, 1'b0);
    endtask

    task automatic wr(int b, logic tk);
        wdata = DW'(b); data_we = 1'b1; tick = tk;
        @(negedge clk);
        data_we = 1'b0; tick = 1'b0;
    endtask

    task automatic load(int v);
        wr(v & 255, 1'b0);
        wr((v >> 8) & 255, 1'b0);
    endtask

    task automatic rd(output int b);
        b = int'(rdata);
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
    endtask

    task automatic rd16(output int v);
        int lo;
        int hi;
        rd(lo);
        rd(hi);
        v = hi * 256 + lo;
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v;
        int cnt;
        @(negedge clk);

        // R12: reset state
        do_reset();
        check("R12 out_bit after reset", int'(out_bit), 0);
        check("R12 cfg_err after reset", int'(cfg_err), 0);
        rd16(v);
        check("R12 count after reset", v, 0);
        wr(8'hAA, 1'b0);
        do_reset();
        load(7);
        rd16(v);
        check("R12 write pointer back at low byte", v, 7);

        // R8 R4 R5 R7: one-shot sweep
        do_reset();
        set_mode(3'b000);
        for (int n = 1; n <= 25; n++) begin
            int len;
            len = (n == 25) ? 300 : n;
            load(len);
            rd16(v);
            check("R4 R5 loaded count read back", v, len);
            check("R3 out low after load", int'(out_bit), 0);
            if (len > 1) begin
                ticks(len - 1);
                check("R8 out low before expiry", int'(out_bit), 0);
                rd16(v);
                check("R7 count one before expiry", v, 1);
            end
            ticks(1);
            check("R8 out high at expiry", int'(out_bit), 1);
            ticks(3);
            rd16(v);
            check("R8 stopped at zero", v, 0);
            check("R8 out stays high", int'(out_bit), 1);
        end

        // R4: zero load does not start
        load(0);
        ticks(5);
        rd16(v);
        check("R4 zero load stays stopped", v, 0);
        check("R4 zero load out low", int'(out_bit), 0);

        // R3 R4 R7: low-byte write stops, high-byte write restarts
        do_reset();
        load(10);
        ticks(3);
        wr(8'h55, 1'b0);
        check("R3 out low after low write", int'(out_bit), 0);
        ticks(4);
        rd16(v);
        check("R3 low byte replaced and stopped", v, 8'h55);
        wr(8'h01, 1'b0);
        rd16(v);
        check("R4 high byte replaced", v, 16'h0155);
        ticks(1);
        rd16(v);
        check("R7 one step per tick", v, 16'h0154);

        // R9: rate generator sweep
        do_reset();
        set_mode(3'b010);
        for (int p = 1; p <= 12; p++) begin
            load(p);
            cnt = p;
            check("R9 out after arm", int'(out_bit), (cnt != 1) ? 1 : 0);
            for (int s = 0; s < 3 * p; s++) begin
                ticks(1);
                cnt = (cnt == 1) ? p : cnt - 1;
                rd16(v);
                check("R9 rate count", v, cnt);
                check("R9 rate out", int'(out_bit), (cnt != 1) ? 1 : 0);
            end
        end

        // R10: square wave sweep
        do_reset();
        set_mode(3'b011);
        for (int p = 1; p <= 12; p++) begin
            load(p);
            cnt = p;
            check("R10 out after arm", int'(out_bit), 1);
            for (int s = 0; s < 3 * p; s++) begin
                ticks(1);
                cnt = (cnt == 1) ? p : cnt - 1;
                rd16(v);
                check("R10 square count", v, cnt);
                check("R10 square out", int'(out_bit), (cnt > p / 2) ? 1 : 0);
            end
        end

        // R6: latch, ignored second latch, release after high byte
        do_reset();
        load(1000);
        ticks(10);
        ctrl(CH, 2'b00, 3'b000, 1'b0);
        ticks(5);
        ctrl(CH, 2'b00, 3'b111, 1'b1);
        check("R1 latch ignores mode and bcd fields", int'(cfg_err), 0);
        ticks(5);
        rd(v);
        check("R6 latched low byte", v, 990 & 255);
        ticks(2);
        rd(v);
        check("R6 second latch ignored, high byte", v, 990 >> 8);
        rd16(v);
        check("R6 released after high byte", v, 978);
        rd(v);
        ctrl(CH, 2'b00, 3'b000, 1'b0);
        ticks(3);
        rd16(v);
        check("R6 latch resets read pointer", v, 978);
        ticks(4);
        rd16(v);
        check("R6 live count after release", v, 971);

        // R1 R2: exhaustive control word sweep
        for (int acc = 1; acc <= 3; acc++) begin
            for (int md = 0; md <= 7; md++) begin
                for (int bcd = 0; bcd <= 1; bcd++) begin
                    int ok;
                    do_reset();
                    ctrl(CH, 2'(acc), 3'(md), 1'(bcd));
                    ok = (acc == 3 && bcd == 0 && (md == 0 || md == 2 || md == 3)) ? 1 : 0;
                    check("R2 R1 cfg_err for control word", int'(cfg_err), 1 - ok);
                end
            end
        end

        // R2: bad settings keep previous mode; error is sticky
        do_reset();
        set_mode(3'b010);
        ctrl(CH, 2'b11, 3'b101, 1'b0);
        ctrl(CH, 2'b11, 3'b011, 1'b1);
        ctrl(CH, 2'b01, 3'b000, 1'b0);
        set_mode(3'b010);
        check("R2 error sticky after valid write", int'(cfg_err), 1);
        load(3);
        ticks(3);
        rd16(v);
        check("R2 rate mode kept after bad writes", v, 3);
        check("R2 rate out at reload", int'(out_bit), 1);

        // R1: other channel selects have no effect
        do_reset();
        ctrl(2'd2, 2'b01, 3'b111, 1'b1);
        ctrl(2'd3, 2'b10, 3'b110, 1'b0);
        check("R1 unselected bad word ignored", int'(cfg_err), 0);
        ctrl(2'd0, 2'b11, 3'b010, 1'b0);
        load(2);
        ticks(2);
        check("R1 unselected mode ignored, one-shot fired", int'(out_bit), 1);
        rd16(v);
        check("R1 one-shot stopped at zero", v, 0);

        // R11: write wins over tick
        do_reset();
        set_mode(3'b010);
        load(5);
        ticks(2);
        wr(8'h20, 1'b1);
        rd16(v);
        check("R11 low write with tick", v, 16'h0020);
        wr(8'h00, 1'b1);
        rd16(v);
        check("R11 high write with tick", v, 16'h0020);
        ticks(1);
        rd16(v);
        check("R7 count after restart", v, 16'h001F);

        summary();
    end
endmodule